// File: doc/BRIEF.md
# Bit-Synchronous SYNC Hunt Receiver

This block sits behind a synchronous serial receive line whose bits arrive with a one-cycle bit strobe derived from the modem's receive clock. While enabled, it shifts in every bit and searches for a 7-bit synchronization code at every bit position. It declares lock only when the same code appears again exactly one 8-bit character later. This two-match rule rejects a single false match caused by line noise.

Once locked, the block splits the bit stream into 8-bit characters. The first bit on the line is character bit 0, and bit 7 carries parity, which the block ignores. Characters whose low seven bits equal the synchronization code are fill and are dropped. Every other character is offered on a valid/ready output. The output is a single holding stage: `char_valid` stays high until `char_ready` is seen high at a clock edge. The line cannot be stalled, so back-pressure is limited. If a newer character completes while the stage is still full, it replaces the older one. The consumer therefore must accept each character within one character time.

`sync_interrupt` pulses when lock is reached. In the alternative mode, it pulses instead on the first character that matches a start-of-text code. A quiet-line timer drops lock after a programmable number of clocks without a bit strobe and pulses `inactivity_error`. Deasserting `enable` ends reception at once.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, and while `enable` is low, `synced`, `char_valid`, `sync_interrupt` and `inactivity_error` are all low.
- R2: `synced` rises only after two matches of `sync_code` exactly eight bits apart. A single match, or a first match whose follow-up 8 bits do not complete a second match, leaves `synced` low and resumes the hunt.
- R3: Lock is found at any bit offset. After lock, characters are assembled on 8-bit boundaries that follow the second code, with the first received bit in `char_data[0]` and the eighth in `char_data[7]`.
- R4: A character whose bits 6..0 equal `sync_code` is never delivered, whatever its bit 7. This includes the one completing the second lock match. All other characters are delivered.
- R5: With `stx_wait` low, `sync_interrupt` is a single-cycle pulse in the cycle `synced` rises, and it does not pulse again while lock holds.
- R6: With `stx_wait` high, no pulse occurs at lock. A single pulse occurs with the first delivered character whose bits 6..0 equal `stx_code`, and that character is still delivered. Later such characters in the same lock raise no pulse.
- R7: `char_valid` and `char_data` hold while `char_ready` is low. A newer character overwrites a held one. A transfer happens on a clock edge where `char_valid` and `char_ready` are both high, and `char_valid` then falls unless a new character completes.
- R8: While `synced`, `IDLE_CYCLES` consecutive clocks without `bit_strobe` make `inactivity_error` pulse for one cycle in the same cycle `synced` falls. The hunt then restarts, and characters received before relock are not delivered.
- R9: Driving `enable` low clears `synced`, `char_valid` and `sync_interrupt` at the next edge. Bits received while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Reception active; low ends reception and drops lock |
| bit_strobe | input | 1 | One-cycle pulse per received line bit |
| rx_bit | input | 1 | Line bit, sampled when `bit_strobe` is high |
| sync_code | input | CHAR_W-1 | Synchronization code, bits 6..0 of the fill character |
| stx_wait | input | 1 | Raise the interrupt on start-of-text instead of at lock |
| stx_code | input | CHAR_W-1 | Start-of-text code compared with bits 6..0 |
| char_data | output | CHAR_W | Delivered character, first line bit in bit 0 |
| char_valid | output | 1 | Holding stage full |
| char_ready | input | 1 | Consumer accepts `char_data` at this edge |
| synced | output | 1 | Character alignment locked |
| sync_interrupt | output | 1 | One-cycle attention pulse |
| inactivity_error | output | 1 | One-cycle pulse when the quiet-line timer expires |

## Verification
The inline assertions check these rules on every cycle:
- entry to lock only from the confirm step on a matching bit;
- no fill character ever visible on the output;
- delivery only after lock;
- holding under back-pressure;
- single-cycle interrupts;
- the timeout pulse coinciding with loss of lock;
- clearing on disable.

Only the bench scenarios show that data fields are correct and that the exact expiry cycle of the idle timer is right. These scenarios include an arbitrary bit offset before lock, the mapping from bit order to field, fill filtering regardless of parity, and overwrite of a held character. They also cover a failed confirmation followed by a clean lock and the once-per-lock start-of-text interrupt.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    HS_OFF     = 2'd0,
    HS_HUNT    = 2'd1,
    HS_CONFIRM = 2'd2,
    HS_LOCKED  = 2'd3
  } hunt_state_e;
endpackage

// File: rtl/shr_window.sv
// Serial-in shift window: newest bit enters the MSB, oldest leaves the LSB.
module shr_window #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] win_next
);
  logic [W-1:0] win_q;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      if (i == W - 1) begin : g_head
        assign win_next[i] = din;
      end else begin : g_body
        assign win_next[i] = win_q[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      win_q <= '0;
    end else if (shift) begin
      win_q <= win_next;
    end
  end
endmodule

// File: rtl/shr_lock_fsm.sv
// Hunt / confirm / locked sequencer.
module shr_lock_fsm import shr_pkg::*; #(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_stb,
  input  logic match,
  input  logic idle_expire,
  output logic lock_pulse,
  output logic synced
);
  localparam int GW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(CHAR_W - 1);

  hunt_state_e  state;
  logic [GW-1:0] gap_q;

  assign lock_pulse = (state == HS_CONFIRM) && bit_stb && (gap_q == GAP_LAST) && match;
  assign synced     = (state == HS_LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= HS_OFF;
      gap_q <= '0;
    end else begin
      case (state)
        HS_OFF: begin
          state <= HS_HUNT;
          gap_q <= '0;
        end
        HS_HUNT: begin
          if (bit_stb && match) begin
            state <= HS_CONFIRM;
            gap_q <= '0;
          end
        end
        HS_CONFIRM: begin
          if (bit_stb) begin
            if (gap_q == GAP_LAST) begin
              state <= match ? HS_LOCKED : HS_HUNT;
              gap_q <= '0;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
        end
        HS_LOCKED: begin
          if (idle_expire) state <= HS_HUNT;
        end
        default: state <= HS_OFF;
      endcase
    end
  end

  // R2: lock is entered only from the confirm step on a matching strobe
  p_lock_via_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_LOCKED && $past(state) != HS_LOCKED)
      |-> ($past(state) == HS_CONFIRM && $past(bit_stb) && $past(match)));
endmodule

// File: rtl/shr_deframer.sv
// Character boundary counter, fill filter and start-of-text detect.
module shr_deframer #(
  parameter int CHAR_W = 8,
  parameter int CODE_W = CHAR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              lock_pulse,
  input  logic              bit_stb,
  input  logic [CHAR_W-1:0] word_next,
  input  logic [CODE_W-1:0] sync_code,
  input  logic              stx_wait,
  input  logic [CODE_W-1:0] stx_code,
  output logic              keep,
  output logic              stx_hit
);
  localparam int CW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CHAR_W - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          done;
  logic          is_fill;

  assign done    = locked && bit_stb && (cnt_q == CNT_LAST);
  assign is_fill = (word_next[CODE_W-1:0] == sync_code);
  assign keep    = done && !is_fill;
  assign stx_hit = keep && stx_wait && armed_q && (word_next[CODE_W-1:0] == stx_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (lock_pulse) begin
      // Second lock code still has its top bit to come: finish it as a fill character.
      cnt_q   <= CNT_LAST;
      armed_q <= 1'b1;
    end else if (!locked) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (bit_stb) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      if (stx_hit) armed_q <= 1'b0;
    end
  end

  // R6: a start-of-text hit disarms further hits for this lock
  p_stx_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stx_hit |=> !stx_hit);
endmodule

// File: rtl/shr_idle_timer.sv
// Counts clocks without a bit strobe while locked.
module shr_idle_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_stb,
  output logic expire,
  output logic err_q
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  assign expire = active && !bit_stb && (cnt_q == T_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= expire;
      if (!active || bit_stb || expire) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: expiry requires a full quiet window since the last strobe
  p_quiet_before_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(active) && !$past(bit_stb));
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
  parameter int CHAR_W      = 8,
  parameter int IDLE_CYCLES = 64,
  localparam int CODE_W     = CHAR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_strobe,
  input  logic              rx_bit,
  input  logic [CODE_W-1:0] sync_code,
  input  logic              stx_wait,
  input  logic [CODE_W-1:0] stx_code,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid,
  input  logic              char_ready,
  output logic              synced,
  output logic              sync_interrupt,
  output logic              inactivity_error
);
  logic [CHAR_W-1:0] win_next;
  logic              stb;
  logic              match;
  logic              lock_pulse;
  logic              idle_expire;
  logic              keep;
  logic              stx_hit;
  logic              hold_valid;
  logic [CHAR_W-1:0] hold_data;
  logic              irq_q;

  assign stb   = enable && bit_strobe;
  assign match = (win_next[CHAR_W-1:1] == sync_code);

  shr_window #(.W(CHAR_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!enable),
    .shift    (stb),
    .din      (rx_bit),
    .win_next (win_next)
  );

  shr_lock_fsm #(.CHAR_W(CHAR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .bit_stb     (stb),
    .match       (match),
    .idle_expire (idle_expire),
    .lock_pulse  (lock_pulse),
    .synced      (synced)
  );

  shr_deframer #(.CHAR_W(CHAR_W), .CODE_W(CODE_W)) u_deframer (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (synced),
    .lock_pulse (lock_pulse),
    .bit_stb    (stb),
    .word_next  (win_next),
    .sync_code  (sync_code),
    .stx_wait   (stx_wait),
    .stx_code   (stx_code),
    .keep       (keep),
    .stx_hit    (stx_hit)
  );

  shr_idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (synced && enable),
    .bit_stb (stb),
    .expire  (idle_expire),
    .err_q   (inactivity_error)
  );

  // Single holding stage; the line cannot stall, so a newer character overwrites.
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= (lock_pulse && !stx_wait) || stx_hit;
      if (keep) begin
        hold_valid <= 1'b1;
        hold_data  <= win_next;
      end else if (hold_valid && char_ready) begin
        hold_valid <= 1'b0;
      end
    end
  end

  assign char_valid     = hold_valid;
  assign char_data      = hold_data;
  assign sync_interrupt = irq_q;

  // R4: fill characters never appear on the output
  p_no_fill_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (char_data[CODE_W-1:0] != sync_code));
  // R3: data only follows lock
  p_data_after_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> $past(synced));
  // R5: interrupt is a one-cycle pulse
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_interrupt |=> !sync_interrupt);
  // R5: in lock-interrupt mode the pulse accompanies the rise of lock
  p_irq_at_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(synced) && !$past(stx_wait)) |-> sync_interrupt);
  // R7: a held character survives back-pressure
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready && enable) |=> char_valid);
  // R8: timeout pulse coincides with loss of lock
  p_error_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inactivity_error |-> !synced);
  // R9: disable clears outputs at the next edge
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!synced && !char_valid && !sync_interrupt));
endmodule

// File: tb/sync_hunt_rx_test.sv
`timescale 1ns/1ps
module sync_hunt_rx_test;
  localparam int IDLE = 40;
  localparam logic [7:0] SYNC = 8'h16;
  // bit 8 = expected delivery, bits 7..0 = character sent after lock
  localparam logic [8:0] VEC [0:7] = '{9'h141, 9'h016, 9'h096, 9'h117,
                                       9'h1C1, 9'h100, 9'h156, 9'h1FF};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, enable, bit_strobe, rx_bit, stx_wait, char_ready;
  logic [6:0] sync_code, stx_code;
  logic [7:0] char_data;
  logic       char_valid, synced, sync_interrupt, inactivity_error;

  sync_hunt_rx #(.CHAR_W(8), .IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_strobe(bit_strobe),
    .rx_bit(rx_bit), .sync_code(sync_code), .stx_wait(stx_wait),
    .stx_code(stx_code), .char_data(char_data), .char_valid(char_valid),
    .char_ready(char_ready), .synced(synced), .sync_interrupt(sync_interrupt),
    .inactivity_error(inactivity_error)
  );

  int checks = 0, failures = 0;
  int n_xfer = 0, n_irq = 0, n_err = 0;
  logic [7:0] last_char = 8'h00;

  always @(negedge clk) begin
    if (char_valid && char_ready) begin n_xfer++; last_char = char_data; end
    if (sync_interrupt) n_irq++;
    if (inactivity_error) n_err++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle(); #1; endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_strobe = 1'b1;
    @(negedge clk); bit_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    for (int i = 0; i < 8; i++) send_bit(c[i]);
  endtask

  task automatic relock();
    send_char(8'hFF); send_char(SYNC); send_char(SYNC);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int x0, i0;
    rst_n = 0; enable = 0; bit_strobe = 0; rx_bit = 0; char_ready = 1;
    stx_wait = 0; sync_code = 7'h16; stx_code = 7'h02;
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R1", "synced", synced, 0);
    chk("R1", "char_valid", char_valid, 0);
    chk("R1", "sync_interrupt", sync_interrupt, 0);
    chk("R1", "inactivity_error", inactivity_error, 0);

    @(negedge clk); enable = 1; repeat (2) @(negedge clk);

    // R2: one code alone does not lock
    send_char(8'hFF); send_char(SYNC); send_char(8'hFF); send_char(8'hFF);
    settle();
    chk("R2", "single code no lock", synced, 0);

    // R3: lock at a three-bit offset
    send_bit(1); send_bit(1); send_bit(1);
    send_char(SYNC);
    for (int i = 0; i < 7; i++) send_bit(SYNC[i]);
    settle();
    chk("R2", "lock after second code", synced, 1);
    chk("R5", "irq at lock", n_irq, 1);
    send_bit(1'b0);
    settle();
    chk("R4", "second code filtered", n_xfer, 0);

    // vector table
    i0 = n_irq;
    for (int v = 0; v < 8; v++) begin
      x0 = n_xfer;
      send_char(VEC[v][7:0]);
      settle();
      chk("R4", "delivery count", n_xfer - x0, int'(VEC[v][8]));
      if (VEC[v][8]) chk("R3", "char field", last_char, VEC[v][7:0]);
    end
    chk("R5", "no repeat irq", n_irq, i0);

    // R7: back-pressure and overwrite
    char_ready = 0; x0 = n_xfer;
    send_char(8'h5A);
    settle();
    chk("R7", "valid held", char_valid, 1);
    chk("R7", "data held", char_data, 8'h5A);
    repeat (6) @(negedge clk);
    settle();
    chk("R7", "still held", char_valid, 1);
    send_char(8'h3C);
    settle();
    chk("R7", "overwrite", char_data, 8'h3C);
    chk("R7", "no transfer while stalled", n_xfer, x0);
    @(negedge clk); char_ready = 1;
    @(negedge clk); settle();
    chk("R7", "one transfer", n_xfer, x0 + 1);
    chk("R7", "transferred value", last_char, 8'h3C);
    chk("R7", "valid cleared", char_valid, 0);

    // R8: quiet line timeout
    send_char(8'h41);
    repeat (37) @(negedge clk);
    settle();
    chk("R8", "lock before expiry", synced, 1);
    @(negedge clk); settle();
    chk("R8", "lock dropped", synced, 0);
    chk("R8", "error pulse", inactivity_error, 1);
    chk("R8", "error count", n_err, 1);
    x0 = n_xfer;
    send_char(8'h41);
    settle();
    chk("R8", "no delivery while hunting", n_xfer, x0);

    // R9: disable
    relock();
    settle();
    chk("R9", "relocked", synced, 1);
    @(negedge clk); enable = 0;
    @(negedge clk); settle();
    chk("R9", "lock cleared", synced, 0);
    x0 = n_xfer;
    relock(); send_char(8'h41);
    settle();
    chk("R9", "ignored while disabled", synced, 0);
    chk("R9", "no data while disabled", n_xfer, x0);
    chk("R1", "valid low while disabled", char_valid, 0);

    // R2: failed confirmation then clean lock
    enable = 1; repeat (2) @(negedge clk);
    send_char(8'hFF); send_char(SYNC); send_char(8'hFF); send_char(8'hFF);
    settle();
    chk("R2", "confirm fail", synced, 0);
    send_char(SYNC); send_char(SYNC);
    settle();
    chk("R2", "lock after retry", synced, 1);

    // R6: interrupt on start-of-text
    @(negedge clk); enable = 0; stx_wait = 1;
    @(negedge clk); enable = 1; repeat (2) @(negedge clk);
    i0 = n_irq;
    relock();
    settle();
    chk("R6", "locked", synced, 1);
    chk("R6", "no irq at lock", n_irq, i0);
    send_char(8'h41);
    settle();
    chk("R6", "no irq on data", n_irq, i0);
    send_char(8'h02);
    settle();
    chk("R6", "irq on stx", n_irq, i0 + 1);
    chk("R6", "stx delivered", last_char, 8'h02);
    send_char(8'h82);
    settle();
    chk("R6", "only first stx", n_irq, i0 + 1);
    chk("R6", "second stx delivered", last_char, 8'h82);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule